// File: doc/BRIEF.md
# Per-Mask Load Pending-Write Tracker

This block sits inside a load/store unit, ahead of a scoreboard that reserves destination registers per (warp, register, lane mask). A load that issues announces one destination register, the warp, the lane mask it runs under and how many memory accesses it splits into. The tracker holds a small content-addressable table of counters keyed by (warp, register, mask) and adds the access count to the matching counter. A primary load contributes under its own active mask, and a co-issued set contributes under the source mask recorded for that set. Every memory access that comes back names the same key and takes one off its counter.

When a counter drains to zero its slot is freed and one release carrying that warp, register and mask is queued toward the scoreboard. Because counts are kept per mask and not summed per register, two loads that write the same register under different masks each free their own reservation at the moment their own accesses finish. A per-(warp, register) total over all masks is still available through a query port. The tracker works only while the mask-aware scoreboard mode is selected and is inert otherwise.

Top module: `mask_pend_tracker`

## Requirements
- R1: An accepted issue with a nonzero register and a nonzero count adds the count to the counter keyed by (warp, register, mask). The mask is `iss_act_mask` when `iss_from_set` is 0 and `iss_set_mask` when it is 1. Register 0 or a count of 0 adds nothing.
- R2: An accepted completion takes one off the counter whose (warp, register, mask) key matches. A completion whose key has no counter changes nothing.
- R3: When a counter reaches zero its entry is removed and exactly one release with the same warp, register and mask is produced.
- R4: Counters for the same warp and register under different masks are independent, and each produces its own release when it drains.
- R5: The tracker acts only when `mode` equals 2'd1. With any other value, issues and completions are ignored, `iss_stall` stays 0 and no release is produced.
- R6: `agg_count` is the sum, over all masks, of the pending counts for warp `agg_warp` and register `agg_reg`.
- R7: The table has 8 slots. An issue that needs a new slot while all 8 are in use raises `iss_stall` in the same cycle and is not recorded. An issue that hits an existing key is still accepted.
- R8: Counters are 6 bits wide. An issue that would push a counter above 63 raises `iss_stall` and is not recorded.
- R9: An issue and a completion that hit the same key in one cycle apply their net change. A release fires only if the resulting count is zero.
- R10: At most one release leaves per cycle, through `rel_valid`/`rel_ready`. `rel_valid` and the release key hold while `rel_ready` is low. Releases leave in the order they were produced, through a 4-entry queue. While the queue is full, `cmp_ready` is 0 and completions are not taken.
- R11: After reset the table is empty: `rel_valid` is 0, `iss_stall` is 0, `cmp_ready` is 1 and `agg_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Scoreboard mode; 2'd1 selects mask-aware tracking |
| iss_valid | input | 1 | Load issue request |
| iss_warp | input | 3 | Issuing warp |
| iss_reg | input | 6 | Destination register (0 = none) |
| iss_act_mask | input | 8 | Active mask of the instruction |
| iss_set_mask | input | 8 | Recorded source mask of a co-issued set |
| iss_from_set | input | 1 | 1 = key on the set mask, 0 = key on the active mask |
| iss_cnt | input | 6 | Number of memory accesses of the load |
| iss_stall | output | 1 | Issue not accepted this cycle |
| cmp_valid | input | 1 | A memory access has completed |
| cmp_warp | input | 3 | Warp of the completed access |
| cmp_reg | input | 6 | Register of the completed access |
| cmp_mask | input | 8 | Recorded source mask of the completed access |
| cmp_ready | output | 1 | Completion can be taken this cycle |
| rel_valid | output | 1 | Release pending toward the scoreboard |
| rel_ready | input | 1 | Scoreboard takes the release |
| rel_warp | output | 3 | Warp of the release |
| rel_reg | output | 6 | Register of the release |
| rel_mask | output | 8 | Mask of the release |
| agg_warp | input | 3 | Warp for the per-register total query |
| agg_reg | input | 6 | Register for the per-register total query |
| agg_count | output | 9 | Pending accesses for that warp and register over all masks |

## Verification
An issue increment and a completion decrement can land on the same counter in the same cycle. The bench provokes this by driving both against a key whose count is 1. A design that applies the two changes one after the other would see zero and release early. The bench judges the case by reading the total through the query port after the edge and by counting the releases that follow.

The second collision is between a completion that would produce a release and a release queue that is already full. The bench holds `rel_ready` low, confirms that the fifth completion is refused, and then checks that the releases drain in order.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
   localparam int          MPT_MODE_W    = 2;
   localparam logic [1:0]  MPT_MODE_MASK = 2'd1;

   typedef enum logic {
      MASK_FROM_INST = 1'b0,
      MASK_FROM_SET  = 1'b1
   } mask_src_e;
endpackage

// File: rtl/mpt_cam_match.sv
module mpt_cam_match #(
   parameter int SLOTS = 8,
   parameter int KEY_W = 17
) (
   input  logic [SLOTS-1:0]            slot_vld,
   input  logic [SLOTS-1:0][KEY_W-1:0] slot_key,
   input  logic [KEY_W-1:0]            probe,
   output logic [SLOTS-1:0]            hit
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
      assign hit[i] = slot_vld[i] && (slot_key[i] == probe);
   end
endmodule

// File: rtl/mpt_first_free.sv
module mpt_first_free #(
   parameter int SLOTS = 8,
   parameter int IDX_W = 3
) (
   input  logic [SLOTS-1:0] busy,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/mpt_rel_queue.sv
module mpt_rel_queue #(
   parameter int DEPTH = 4,
   parameter int DW    = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("mpt_rel_queue: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic          vld_q;
      logic [DW-1:0] data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
         end else if (push && !vld_q) begin
            vld_q  <= 1'b1;
            data_q <= push_data;
         end else if (vld_q && out_ready) begin
            vld_q  <= 1'b0;
         end
      end
      assign full      = vld_q;
      assign out_valid = vld_q;
      assign out_data  = data_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [DW-1:0] mem [DEPTH];
      logic [PW-1:0] wp, rp;
      logic [CW-1:0] fill;
      logic          do_push, do_pop;

      assign full      = (fill == CW'(DEPTH));
      assign out_valid = (fill != '0);
      assign out_data  = mem[rp];
      assign do_push   = push && !full;
      assign do_pop    = out_valid && out_ready;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else begin
            if (do_push) begin
               mem[wp] <= push_data;
               wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
               2'b10:   fill <= fill + 1'b1;
               2'b01:   fill <= fill - 1'b1;
               default: fill <= fill;
            endcase
         end
      end
   end
endmodule

// File: rtl/mask_pend_tracker.sv
module mask_pend_tracker
   import mpt_pkg::*;
#(
   parameter int WARP_W = 3,
   parameter int REG_W  = 6,
   parameter int MASK_W = 8,
   parameter int SLOTS  = 8,
   parameter int CNT_W  = 6,
   parameter int QDEPTH = 4,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int AGG_W = CNT_W + IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MPT_MODE_W-1:0] mode,
   input  logic                  iss_valid,
   input  logic [WARP_W-1:0]     iss_warp,
   input  logic [REG_W-1:0]      iss_reg,
   input  logic [MASK_W-1:0]     iss_act_mask,
   input  logic [MASK_W-1:0]     iss_set_mask,
   input  logic                  iss_from_set,
   input  logic [CNT_W-1:0]      iss_cnt,
   output logic                  iss_stall,
   input  logic                  cmp_valid,
   input  logic [WARP_W-1:0]     cmp_warp,
   input  logic [REG_W-1:0]      cmp_reg,
   input  logic [MASK_W-1:0]     cmp_mask,
   output logic                  cmp_ready,
   output logic                  rel_valid,
   input  logic                  rel_ready,
   output logic [WARP_W-1:0]     rel_warp,
   output logic [REG_W-1:0]      rel_reg,
   output logic [MASK_W-1:0]     rel_mask,
   input  logic [WARP_W-1:0]     agg_warp,
   input  logic [REG_W-1:0]      agg_reg,
   output logic [AGG_W-1:0]      agg_count
);
   localparam int KEY_W   = WARP_W + REG_W + MASK_W;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("mask_pend_tracker: SLOTS must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("mask_pend_tracker: CNT_W must be at least 2");
   end
   if (WARP_W < 1 || REG_W < 1 || MASK_W < 1) begin : g_bad_key
      $error("mask_pend_tracker: key fields must be at least one bit");
   end

   logic                       enabled;
   logic [MASK_W-1:0]          iss_mask_sel;
   logic [KEY_W-1:0]           iss_key, cmp_key, rel_key;
   logic [SLOTS-1:0]           slot_vld;
   logic [SLOTS-1:0][KEY_W-1:0] slot_key;
   logic [SLOTS-1:0][CNT_W-1:0] slot_cnt;
   logic [SLOTS-1:0]           iss_hit, cmp_hit, ovf_vec, zero_vec;
   logic                       free_found;
   logic [IDX_W-1:0]           free_idx;
   logic                       iss_live, iss_any_hit, iss_take, cmp_take;
   logic                       q_full, rel_push;

   assign enabled = (mode == MPT_MODE_MASK);

   always_comb begin
      case (mask_src_e'(iss_from_set))
         MASK_FROM_SET: iss_mask_sel = iss_set_mask;
         default:       iss_mask_sel = iss_act_mask;
      endcase
   end

   assign iss_key = {iss_warp, iss_reg, iss_mask_sel};
   assign cmp_key = {cmp_warp, cmp_reg, cmp_mask};

   mpt_cam_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_iss_cam (
      .slot_vld(slot_vld), .slot_key(slot_key), .probe(iss_key), .hit(iss_hit)
   );
   mpt_cam_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_cmp_cam (
      .slot_vld(slot_vld), .slot_key(slot_key), .probe(cmp_key), .hit(cmp_hit)
   );
   mpt_first_free #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_free (
      .busy(slot_vld), .found(free_found), .idx(free_idx)
   );

   assign iss_live    = iss_valid && enabled && (iss_reg != '0) && (iss_cnt != '0);
   assign iss_any_hit = |iss_hit;
   assign iss_stall   = iss_live && (iss_any_hit ? (|ovf_vec) : !free_found);
   assign iss_take    = iss_live && !iss_stall;
   assign cmp_ready   = !q_full;
   assign cmp_take    = cmp_valid && enabled && !q_full;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic             inc, dec, alloc;
      logic [CNT_W:0]   grown, net;

      assign grown = (CNT_W + 1)'(slot_cnt[i]) + (CNT_W + 1)'(iss_cnt);
      assign ovf_vec[i] = iss_hit[i] && (grown > (CNT_W + 1)'(CNT_MAX));

      assign inc   = iss_take && iss_hit[i];
      assign dec   = cmp_take && cmp_hit[i];
      assign alloc = iss_take && !iss_any_hit && (free_idx == IDX_W'(i));

      always_comb begin
         net = (CNT_W + 1)'(slot_cnt[i]);
         if (inc) net = net + (CNT_W + 1)'(iss_cnt);
         if (dec) net = net - 1'b1;
      end

      assign zero_vec[i] = dec && (net == '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_vld[i] <= 1'b0;
            slot_key[i] <= '0;
            slot_cnt[i] <= '0;
         end else if (alloc) begin
            slot_vld[i] <= 1'b1;
            slot_key[i] <= iss_key;
            slot_cnt[i] <= iss_cnt;
         end else if (inc || dec) begin
            slot_cnt[i] <= net[CNT_W-1:0];
            if (net == '0) slot_vld[i] <= 1'b0;
         end
      end
   end

   assign rel_push = |zero_vec;

   mpt_rel_queue #(.DEPTH(QDEPTH), .DW(KEY_W)) u_relq (
      .clk(clk), .rst_n(rst_n),
      .push(rel_push), .push_data(cmp_key), .full(q_full),
      .out_valid(rel_valid), .out_data(rel_key), .out_ready(rel_ready)
   );

   assign {rel_warp, rel_reg, rel_mask} = rel_key;

   always_comb begin
      agg_count = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (slot_vld[i] && (slot_key[i][KEY_W-1:MASK_W] == {agg_warp, agg_reg}))
            agg_count = agg_count + AGG_W'(slot_cnt[i]);
      end
   end
endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
   parameter int WARP_W = 3,
   parameter int REG_W  = 6,
   parameter int MASK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              iss_valid,
   input logic              iss_stall,
   input logic              cmp_ready,
   input logic              rel_valid,
   input logic              rel_ready,
   input logic [WARP_W-1:0] rel_warp,
   input logic [REG_W-1:0]  rel_reg,
   input logic [MASK_W-1:0] rel_mask
);
   // R10: a release not taken stays offered with the same key
   assert_rel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_warp) &&
                                     $stable(rel_reg) && $stable(rel_mask)));

   // R10: completions are refused only while releases are waiting
   assert_refuse_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_ready |-> rel_valid);

   // R5: no stall outside mask-aware mode
   assert_no_stall_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd1) |-> !iss_stall);

   // R5: no new release is produced outside mask-aware mode
   assert_no_release_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != 2'd1) && !rel_valid) |=> !rel_valid);

   // R7: a stall is only ever raised against a present issue
   assert_stall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall |-> iss_valid);

   // R11: reset leaves no release pending
   assert_reset_empty_R11: assert property (@(posedge clk)
      !rst_n |=> !rel_valid);
endmodule

bind mask_pend_tracker mpt_checker #(
   .WARP_W(WARP_W), .REG_W(REG_W), .MASK_W(MASK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .iss_valid(iss_valid),
   .iss_stall(iss_stall), .cmp_ready(cmp_ready), .rel_valid(rel_valid),
   .rel_ready(rel_ready), .rel_warp(rel_warp), .rel_reg(rel_reg),
   .rel_mask(rel_mask)
);

// File: tb/mask_pend_tracker_test.sv
`timescale 1ns/100ps
module mask_pend_tracker_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic       iss_valid, iss_from_set, iss_stall;
   logic [2:0] iss_warp, cmp_warp, rel_warp, agg_warp;
   logic [5:0] iss_reg, cmp_reg, rel_reg, agg_reg, iss_cnt;
   logic [7:0] iss_act_mask, iss_set_mask, cmp_mask, rel_mask;
   logic       cmp_valid, cmp_ready, rel_valid, rel_ready;
   logic [8:0] agg_count;

   int vectors = 0;
   int errors  = 0;
   int rel_n   = 0;
   logic [16:0] rel_log [0:63];
   bit done = 0;

   always #2.5 clk = ~clk;

   mask_pend_tracker uut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_reg(iss_reg),
      .iss_act_mask(iss_act_mask), .iss_set_mask(iss_set_mask),
      .iss_from_set(iss_from_set), .iss_cnt(iss_cnt), .iss_stall(iss_stall),
      .cmp_valid(cmp_valid), .cmp_warp(cmp_warp), .cmp_reg(cmp_reg),
      .cmp_mask(cmp_mask), .cmp_ready(cmp_ready),
      .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_warp(rel_warp),
      .rel_reg(rel_reg), .rel_mask(rel_mask),
      .agg_warp(agg_warp), .agg_reg(agg_reg), .agg_count(agg_count)
   );

   always @(posedge clk) begin
      if (rst_n && rel_valid && rel_ready) begin
         if (rel_n < 64) rel_log[rel_n] <= {rel_warp, rel_reg, rel_mask};
         rel_n <= rel_n + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      iss_valid = 1'b0;
      cmp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic issue(input int w, input int r, input int am, input int sm,
                        input bit fs, input int n);
      iss_valid = 1'b1; iss_warp = 3'(w); iss_reg = 6'(r);
      iss_act_mask = 8'(am); iss_set_mask = 8'(sm);
      iss_from_set = fs; iss_cnt = 6'(n);
   endtask

   task automatic compl(input int w, input int r, input int m);
      cmp_valid = 1'b1; cmp_warp = 3'(w); cmp_reg = 6'(r); cmp_mask = 8'(m);
   endtask

   task automatic agg(input int w, input int r, output int v);
      agg_warp = 3'(w); agg_reg = 6'(r);
      #0.1;
      v = int'(agg_count);
   endtask

   function automatic int key(input int w, input int r, input int m);
      return (w << 14) | (r << 8) | m;
   endfunction

   task automatic t_basic();
      int base = rel_n; int v;
      issue(1, 5, 'h0F, 'hF0, 0, 3); tick();
      agg(1, 5, v); chk("R1 count added", v, 3);
      agg(1, 6, v); chk("R6 other register total", v, 0);
      compl(1, 5, 'h0F); tick(); compl(1, 5, 'h0F); tick(); idle(2);
      chk("R3 no early release", rel_n - base, 0);
      agg(1, 5, v); chk("R2 decrement", v, 1);
      compl(1, 5, 'h0F); tick(); idle(2);
      chk("R3 one release", rel_n - base, 1);
      chk("R1 R3 release key uses active mask", int'(rel_log[base]), key(1, 5, 'h0F));
      agg(1, 5, v); chk("R3 entry removed", v, 0);
   endtask

   task automatic t_masks();
      int base = rel_n; int v;
      issue(2, 7, 'hF0, 'h00, 0, 1); tick();
      issue(2, 7, 'hFF, 'h0C, 1, 2); tick();
      agg(2, 7, v); chk("R6 total over masks", v, 3);
      compl(2, 7, 'h0C); tick(); idle(2);
      chk("R4 set mask not drained", rel_n - base, 0);
      compl(2, 7, 'hF0); tick(); idle(2);
      chk("R4 own release", rel_n - base, 1);
      chk("R4 release mask F0", int'(rel_log[base]), key(2, 7, 'hF0));
      agg(2, 7, v); chk("R4 other mask still pending", v, 1);
      compl(2, 7, 'h0C); tick(); idle(2);
      chk("R4 second release", rel_n - base, 2);
      chk("R1 release keyed by set mask", int'(rel_log[base + 1]), key(2, 7, 'h0C));
   endtask

   task automatic t_ignored();
      int base = rel_n; int v;
      issue(3, 3, 'h01, 'h00, 0, 2); tick();
      compl(3, 3, 'h02); tick(); compl(3, 4, 'h01); tick(); idle(2);
      agg(3, 3, v); chk("R2 unmatched decrement ignored", v, 2);
      chk("R2 unmatched no release", rel_n - base, 0);
      issue(3, 0, 'h01, 'h00, 0, 5); tick();
      agg(3, 0, v); chk("R1 register zero ignored", v, 0);
      issue(3, 6, 'h01, 'h00, 0, 0); tick();
      agg(3, 6, v); chk("R1 zero count ignored", v, 0);
      compl(3, 3, 'h01); tick(); compl(3, 3, 'h01); tick(); idle(2);
      chk("R3 drain after ignored", rel_n - base, 1);
   endtask

   task automatic t_mode();
      int base = rel_n; int v;
      issue(4, 9, 'h81, 'h00, 0, 1); tick();
      mode = 2'd0;
      issue(4, 11, 'h81, 'h00, 0, 2); tick();
      agg(4, 11, v); chk("R5 issue ignored in mode 0", v, 0);
      compl(4, 9, 'h81); tick(); idle(2);
      chk("R5 no release in mode 0", rel_n - base, 0);
      agg(4, 9, v); chk("R5 completion ignored in mode 0", v, 1);
      mode = 2'd2;
      issue(4, 12, 'h81, 'h00, 0, 2); tick();
      agg(4, 12, v); chk("R5 issue ignored in mode 2", v, 0);
      mode = 2'd1;
      compl(4, 9, 'h81); tick(); idle(2);
      chk("R5 release once mode 1", rel_n - base, 1);
   endtask

   task automatic t_same();
      int base = rel_n; int v;
      issue(1, 40, 'h3C, 'h00, 0, 1); tick();
      issue(1, 40, 'h3C, 'h00, 0, 1); compl(1, 40, 'h3C); tick(); idle(2);
      agg(1, 40, v); chk("R9 net change", v, 1);
      chk("R9 no release on net nonzero", rel_n - base, 0);
      compl(1, 40, 'h3C); tick(); idle(2);
      chk("R9 release after drain", rel_n - base, 1);
   endtask

   task automatic t_full();
      int base = rel_n; int v;
      for (int i = 0; i < 8; i++) begin
         issue(5, 10 + i, 'h01, 'h00, 0, 1); tick();
      end
      issue(5, 20, 'h01, 'h00, 0, 1); #0.5;
      chk("R7 stall when full", int'(iss_stall), 1);
      tick();
      agg(5, 20, v); chk("R7 stalled issue not recorded", v, 0);
      issue(5, 10, 'h01, 'h00, 0, 1); #0.5;
      chk("R7 hit accepted when full", int'(iss_stall), 0);
      tick();
      agg(5, 10, v); chk("R7 hit counted", v, 2);
      compl(5, 10, 'h01); tick();
      for (int i = 0; i < 8; i++) begin
         compl(5, 10 + i, 'h01); tick();
      end
      idle(2);
      chk("R3 full table drained", rel_n - base, 8);
   endtask

   task automatic t_ovf();
      int base = rel_n; int v;
      issue(6, 20, 'hAA, 'h00, 0, 60); tick();
      issue(6, 20, 'hAA, 'h00, 0, 4); #0.5;
      chk("R8 overflow stall", int'(iss_stall), 1);
      tick();
      agg(6, 20, v); chk("R8 overflow not recorded", v, 60);
      issue(6, 20, 'hAA, 'h00, 0, 3); #0.5;
      chk("R8 fill to 63 accepted", int'(iss_stall), 0);
      tick();
      agg(6, 20, v); chk("R8 count at max", v, 63);
      for (int i = 0; i < 63; i++) begin
         compl(6, 20, 'hAA); tick();
      end
      idle(2);
      chk("R3 max count drains once", rel_n - base, 1);
   endtask

   task automatic t_queue();
      int base = rel_n; int v;
      rel_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin
         issue(7, 30 + i, 'h11, 'h00, 0, 1); tick();
      end
      for (int i = 0; i < 4; i++) begin
         compl(7, 30 + i, 'h11); tick();
      end
      idle(1);
      chk("R10 release held", int'(rel_valid), 1);
      chk("R10 cmp_ready low when full", int'(cmp_ready), 0);
      compl(7, 34, 'h11); tick();
      agg(7, 34, v); chk("R10 refused completion not taken", v, 1);
      chk("R10 nothing taken while not ready", rel_n - base, 0);
      rel_ready = 1'b1;
      idle(6);
      chk("R10 four released", rel_n - base, 4);
      for (int i = 0; i < 4; i++)
         chk("R10 release order", int'(rel_log[base + i]), key(7, 30 + i, 'h11));
      chk("R10 cmp_ready back", int'(cmp_ready), 1);
      compl(7, 34, 'h11); tick(); idle(2);
      chk("R10 last release", rel_n - base, 5);
   endtask

   initial begin
      int v;
      rst_n = 1'b0; mode = 2'd1; rel_ready = 1'b1;
      iss_valid = 0; iss_warp = 0; iss_reg = 0; iss_act_mask = 0;
      iss_set_mask = 0; iss_from_set = 0; iss_cnt = 0;
      cmp_valid = 0; cmp_warp = 0; cmp_reg = 0; cmp_mask = 0;
      agg_warp = 0; agg_reg = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R11 rel_valid at reset", int'(rel_valid), 0);
      chk("R11 cmp_ready at reset", int'(cmp_ready), 1);
      chk("R11 stall at reset", int'(iss_stall), 0);
      agg(0, 0, v); chk("R11 empty table", v, 0);
      rst_n = 1'b1;
      idle(1);
      t_basic();
      t_masks();
      t_ignored();
      t_mode();
      t_same();
      t_full();
      t_ovf();
      t_queue();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         vectors++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule